// File: doc/BRIEF.md
# Mode-Banked Register File

This block is the architectural register store for a small 32-bit core that runs in one of seven operating modes. Software addresses sixteen registers by a 4-bit index, but the physical register behind an index depends on the 5-bit mode code presented on the `mode` input. The low eight indices are common to all modes. Indices 8 to 12 have a private copy for the fast-interrupt mode. Indices 13 and 14 have a copy for each privileged mode, plus one copy that user and system mode share. Together with the program counter this gives 31 physical registers.

Two combinational read ports and one clocked write port serve the datapath. Index 15 is the program counter. It advances by one instruction word per cycle when `pc_adv` is high, and it can be loaded through the write port. A read of index 15 returns the current instruction address plus eight, the value a pipelined core exposes to software. A mode code outside the seven defined ones selects the user bank and sets a sticky error flag.

Top module: `banked_regfile`

## Requirements
- R1: After reset every general register reads zero, `pc_addr` equals the reset address with bits 1:0 cleared, and `mode_err` is low.
- R2: Indices 0 to 7 name one physical register each, so a value written in any mode reads back the same in every mode.
- R3: Indices 8 to 12 select a private copy in fast-interrupt mode (code 10001) and a common copy in all other modes.
- R4: Indices 13 and 14 select one of six copies: user (10000) and system (11111) share one, and fast interrupt (10001), normal interrupt (10010), supervisor (10011), abort (10111) and undefined (11011) each have their own.
- R5: A read of index 15 on either port returns `pc_addr + 8`. The two read ports are independent of each other.
- R6: Bits 1:0 of `pc_addr` are always zero.
- R7: With `pc_adv` high, `pc_addr` grows by 4 at each clock edge. A write to index 15 loads `wr_data` with bits 1:0 cleared and takes priority over the advance in that cycle. With neither, `pc_addr` holds.
- R8: A mode code other than the seven above selects the user/system bank for all indices. From the next clock edge `mode_err` is high, and it stays high until reset.
- R9: A read of the register being written in the same cycle returns the old value. The new value is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 5 | Current operating mode code |
| rd_a_idx | input | 4 | Read port A register index |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B register index |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Write register index |
| wr_data | input | 32 | Write data |
| pc_adv | input | 1 | Advance the program counter by one word |
| pc_addr | output | 32 | Current instruction address |
| mode_err | output | 1 | Sticky flag for an invalid mode code |

## Verification
The assertions check the program counter on every cycle: its alignment, the plus-eight read view on both ports, the advance, hold and load rules with their priority, and the setting and stickiness of the error flag. Which physical copy an index reaches in each mode, the separation between banks, the fallback of unknown codes to the user bank, and old-value reads during a write depend on stored history. Only the bench's reference model can show these, by writing distinct values in every mode and reading them back across mode changes.

// File: rtl/banked_regfile.sv
module banked_regfile #(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] RESET_PC = '0,
  parameter int PC_STEP = 4,
  parameter int PC_AHEAD = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        mode,
  input  logic [3:0]        rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [3:0]        rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [3:0]        wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pc_adv,
  output logic [DATA_W-1:0] pc_addr,
  output logic              mode_err
);
  localparam int N_LOW   = 8;
  localparam int N_MID   = 5;
  localparam int N_SPLR  = 2;
  localparam int N_BANKS = 6;
  localparam int MID_BASE  = N_LOW;
  localparam int FIQ_BASE  = MID_BASE + N_MID;
  localparam int SPLR_BASE = FIQ_BASE + N_MID;
  localparam int N_GPR   = SPLR_BASE + N_BANKS * N_SPLR;
  localparam int SLOT_W  = $clog2(N_GPR);
  localparam logic [3:0] PC_IDX = 4'd15;

  localparam logic [4:0] M_USR = 5'b10000;
  localparam logic [4:0] M_FIQ = 5'b10001;
  localparam logic [4:0] M_IRQ = 5'b10010;
  localparam logic [4:0] M_SVC = 5'b10011;
  localparam logic [4:0] M_ABT = 5'b10111;
  localparam logic [4:0] M_UND = 5'b11011;
  localparam logic [4:0] M_SYS = 5'b11111;

  function automatic int bank_of(input logic [4:0] m);
    case (m)
      M_FIQ:   return 1;
      M_IRQ:   return 2;
      M_SVC:   return 3;
      M_ABT:   return 4;
      M_UND:   return 5;
      default: return 0;
    endcase
  endfunction

  function automatic logic [SLOT_W-1:0] slot_of(input logic [4:0] m, input logic [3:0] idx);
    int i, s;
    i = int'(idx);
    if (i < N_LOW)                 s = i;
    else if (i < N_LOW + N_MID)    s = (m == M_FIQ) ? FIQ_BASE + i - N_LOW : MID_BASE + i - N_LOW;
    else if (i < N_LOW + N_MID + N_SPLR)
                                   s = SPLR_BASE + bank_of(m) * N_SPLR + i - (N_LOW + N_MID);
    else                           s = 0;
    return SLOT_W'(s);
  endfunction

  logic [DATA_W-1:0] gpr [N_GPR];
  logic [DATA_W-1:0] pc_q;
  logic              mode_ok;
  logic              wr_pc;

  assign mode_ok = (mode == M_USR) || (mode == M_FIQ) || (mode == M_IRQ) || (mode == M_SVC) ||
                   (mode == M_ABT) || (mode == M_UND) || (mode == M_SYS);
  assign wr_pc   = wr_en && (wr_idx == PC_IDX);
  assign pc_addr = pc_q;

  assign rd_a_data = (rd_a_idx == PC_IDX) ? pc_q + DATA_W'(PC_AHEAD) : gpr[slot_of(mode, rd_a_idx)];
  assign rd_b_data = (rd_b_idx == PC_IDX) ? pc_q + DATA_W'(PC_AHEAD) : gpr[slot_of(mode, rd_b_idx)];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_GPR; i++) gpr[i] <= '0;
      pc_q     <= {RESET_PC[DATA_W-1:2], 2'b00};
      mode_err <= 1'b0;
    end else begin
      if (wr_en && !wr_pc) gpr[slot_of(mode, wr_idx)] <= wr_data;
      if (wr_pc)       pc_q <= {wr_data[DATA_W-1:2], 2'b00};
      else if (pc_adv) pc_q <= pc_q + DATA_W'(PC_STEP);
      if (!mode_ok) mode_err <= 1'b1;
    end
  end
endmodule

// File: rtl/banked_regfile_checks.sv
module banked_regfile_checks #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [4:0]        mode,
  input logic [3:0]        rd_a_idx,
  input logic [DATA_W-1:0] rd_a_data,
  input logic [3:0]        rd_b_idx,
  input logic [DATA_W-1:0] rd_b_data,
  input logic              wr_en,
  input logic [3:0]        wr_idx,
  input logic [DATA_W-1:0] wr_data,
  input logic              pc_adv,
  input logic [DATA_W-1:0] pc_addr,
  input logic              mode_err
);
  logic known;
  logic ld;
  assign known = mode inside {5'b10000, 5'b10001, 5'b10010, 5'b10011, 5'b10111, 5'b11011, 5'b11111};
  assign ld    = wr_en && (wr_idx == 4'hf);

  p_pc_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n) pc_addr[1:0] == 2'b00);
  p_read_a_pc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == 4'hf) |-> (rd_a_data == pc_addr + DATA_W'(8)));
  p_read_b_pc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_b_idx == 4'hf) |-> (rd_b_data == pc_addr + DATA_W'(8)));
  p_pc_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (pc_addr == {$past(wr_data[DATA_W-1:2]), 2'b00}));
  p_pc_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && pc_adv) |=> (pc_addr == $past(pc_addr) + DATA_W'(4)));
  p_pc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !pc_adv) |=> $stable(pc_addr));
  p_err_set_r8: assert property (@(posedge clk) disable iff (!rst_n) !known |=> mode_err);
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n) mode_err |=> mode_err);
endmodule

bind banked_regfile banked_regfile_checks #(.DATA_W(DATA_W)) u_checks (
  .clk(clk), .rst_n(rst_n), .mode(mode),
  .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
  .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
  .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
  .pc_adv(pc_adv), .pc_addr(pc_addr), .mode_err(mode_err)
);

// File: tb/banked_regfile_bench.sv
`timescale 1ns/1ps
module banked_regfile_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  mode = 5'b10000;
  logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = '0, pc_addr;
  logic        wr_en = 1'b0, pc_adv = 1'b0, mode_err;

  int errors = 0;
  int checks = 0;
  logic [31:0] mem [string];
  logic [31:0] ref_pc = 32'h0;
  logic        ref_err = 1'b0;
  logic [4:0]  modes [8] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011,
                             5'b10111, 5'b11011, 5'b11111, 5'b10100};

  always #2 clk = ~clk;

  banked_regfile u_banked_regfile (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .pc_adv(pc_adv), .pc_addr(pc_addr), .mode_err(mode_err)
  );

  function automatic bit valid_mode(input logic [4:0] m);
    for (int k = 0; k < 7; k++) if (modes[k] == m) return 1'b1;
    return 1'b0;
  endfunction

  function automatic string key(input logic [4:0] m, input int i);
    string b;
    if (i < 8) return $sformatf("low%0d", i);
    case (m)
      5'b10001: b = "fiq";
      5'b10010: b = "irq";
      5'b10011: b = "svc";
      5'b10111: b = "abt";
      5'b11011: b = "und";
      default:  b = "usr";
    endcase
    if (i < 13) return (b == "fiq") ? $sformatf("mid%0d_fiq", i) : $sformatf("mid%0d", i);
    return $sformatf("top%0d_%s", i, b);
  endfunction

  function automatic logic [31:0] expect_rd(input logic [4:0] m, input int i);
    string k;
    if (i == 15) return ref_pc + 32'd8;
    k = key(m, i);
    return mem.exists(k) ? mem[k] : 32'h0;
  endfunction

  function automatic string tag_of(input logic [4:0] m, input int i, input bit coll);
    if (coll) return "R9";
    if (!valid_mode(m)) return "R8";
    if (i < 8) return "R2";
    if (i < 13) return "R3";
    if (i < 15) return "R4";
    return "R5";
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input logic [4:0] m, input int ai, input int bi,
                     input bit we, input int wi, input logic [31:0] wd, input bit adv);
    bit ca, cb;
    @(negedge clk);
    mode = m; rd_a_idx = 4'(ai); rd_b_idx = 4'(bi);
    wr_en = we; wr_idx = 4'(wi); wr_data = wd; pc_adv = adv;
    #1;
    ca = we && (wi == ai) && (wi != 15) && (key(m, wi) == key(m, ai));
    cb = we && (wi == bi) && (wi != 15) && (key(m, wi) == key(m, bi));
    check(tag_of(m, ai, ca), $sformatf("port A idx %0d mode %b", ai, m), rd_a_data, expect_rd(m, ai));
    check(tag_of(m, bi, cb), $sformatf("port B idx %0d mode %b", bi, m), rd_b_data, expect_rd(m, bi));
    check("R7", "pc_addr", pc_addr, ref_pc);
    check("R6", "pc low bits", {30'h0, pc_addr[1:0]}, 32'h0);
    check("R8", "mode_err", {31'h0, mode_err}, {31'h0, ref_err});
    @(posedge clk);
    if (we && wi == 15)      ref_pc = {wd[31:2], 2'b00};
    else if (adv)            ref_pc = ref_pc + 32'd4;
    if (we && wi != 15)      mem[key(m, wi)] = wd;
    if (!valid_mode(m))      ref_err = 1'b1;
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: reset state across every index
    for (int i = 0; i < 15; i++) begin
      @(negedge clk); rd_a_idx = 4'(i); #1;
      check("R1", $sformatf("reset idx %0d", i), rd_a_data, 32'h0);
    end
    check("R1", "reset pc", pc_addr, 32'h0);
    check("R1", "reset mode_err", {31'h0, mode_err}, 32'h0);

    // R2 R3 R4: distinct values in every valid mode, then cross reads
    for (int k = 0; k < 7; k++)
      for (int i = 0; i < 15; i++)
        cyc(modes[k], 0, 15, 1'b1, i, {4'(k), 20'h0, 8'(i)} ^ 32'hA5000000, 1'b0);
    for (int k = 0; k < 7; k++)
      for (int i = 0; i < 15; i++)
        cyc(modes[k], i, 14 - i, 1'b0, 0, 32'h0, 1'b0);

    // R5 R6 R7: advance, load with low bits set, load beating advance
    for (int n = 0; n < 6; n++) cyc(5'b10011, 15, 15, 1'b0, 0, 32'h0, 1'b1);
    cyc(5'b10011, 15, 3, 1'b1, 15, 32'h0000_1003, 1'b1);
    cyc(5'b10011, 15, 15, 1'b1, 15, 32'hFFFF_FFFE, 1'b0);
    cyc(5'b10000, 15, 15, 1'b0, 0, 32'h0, 1'b1);
    cyc(5'b10000, 15, 15, 1'b0, 0, 32'h0, 1'b0);

    // R9: same-cycle write and read of the same register
    cyc(5'b10001, 9, 13, 1'b1, 9, 32'h1234_5678, 1'b0);
    cyc(5'b10001, 9, 13, 1'b1, 13, 32'hCAFE_F00D, 1'b0);
    cyc(5'b10001, 9, 13, 1'b0, 0, 32'h0, 1'b0);

    // R8: unknown code falls back to the user bank and flags
    cyc(5'b10100, 13, 8, 1'b1, 14, 32'hDEAD_0014, 1'b0);
    cyc(5'b10000, 14, 13, 1'b0, 0, 32'h0, 1'b0);
    cyc(5'b11111, 14, 8, 1'b0, 0, 32'h0, 1'b0);
    cyc(5'b10010, 14, 8, 1'b0, 0, 32'h0, 1'b0);

    // mixed traffic
    for (int n = 0; n < 600; n++)
      cyc(modes[$urandom_range(0, 7)], $urandom_range(0, 15), $urandom_range(0, 15),
          1'($urandom_range(0, 1)), $urandom_range(0, 15), $urandom, 1'($urandom_range(0, 1)));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule